// File: doc/BRIEF.md
# Biphase infrared frame decoder

This block turns the output of an infrared demodulator into the address and command of a remote-control frame. The demodulator output is active low and idles high. Each frame carries two start bits and then twelve data bits in biphase code. The decoder brings the raw line into the clock domain through two flops and finds its edges. It measures time in coarse ticks made from the system clock by an internal divider.

After the start bits, the decoder samples each data bit a fixed number of ticks after the last reference edge. It then waits for the transition in the middle of that bit. Its direction is rising when the sample was low and falling when it was high. That edge restarts the tick timer, so every bit realigns the sampling point and slow drift in the sender's bit rate does no harm. An edge that fails to arrive within the watchdog window aborts the frame. When a frame ends, well formed or not, the block gives a single-cycle result pulse. An error flag tells the two apart, and on an error both output fields are saturated to all ones.

Top module: `ir_biphase_rx`

## Requirements
- R1: After a synchronous reset, `sys_addr` and `cmd` are 0 and `result_valid` and `result_err` are low.
- R2: Only a falling edge of `ir_n` that follows a high level starts a frame. A line that stays steadily low or steadily high produces no result.
- R3: After the first falling edge, a rising edge must arrive before `TQ_TICKS` ticks, and after that a falling edge (second start bit) must arrive before `TQ_TICKS` ticks. If either is missing, the frame ends with a fault.
- R4: Twelve data bits follow the start bits. Each is taken from the line level `Q_TICKS` ticks after the last reference edge, where high gives 1 and low gives 0.
- R5: After a 0 sample the decoder waits for a rising edge, and after a 1 sample for a falling edge. That edge restarts the tick timer, so varying bit lengths inside the window are decoded correctly.
- R6: If the expected mid-bit edge has not arrived by the time the timer reaches `TQ_TICKS`, the frame ends with a fault.
- R7: On a fault, `result_err` is 1 and both `sys_addr` and `cmd` are 8'hFF.
- R8: On success, the first data bit received goes to `cmd[6]`. The next five, MSB first, form `sys_addr[4:0]`, and the last six, MSB first, form `cmd[5:0]`. `cmd[7]` and `sys_addr[7:5]` are 0.
- R9: Every frame result gives exactly one `result_valid` pulse of one cycle, and the outputs hold their value until the next result.
- R10: The timer advances once every `TICK_DIV` clock cycles, so a fault for a missing edge is reported about `TQ_TICKS*TICK_DIV` cycles after the last accepted edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_n | input | 1 | Asynchronous demodulator output, active low, idles high |
| sys_addr | output | 8 | System address (5 bits, zero-extended), or 8'hFF on fault |
| cmd | output | 8 | Toggle flag in bit 6 and 6-bit command below it, or 8'hFF on fault |
| result_valid | output | 1 | One-cycle pulse when a frame result is presented |
| result_err | output | 1 | High with the pulse when the frame was aborted |

## Verification
The mid-bit edge and the watchdog expiry can fall in the same cycle. The rule is that the timeout wins once the timer has reached its limit, and an edge seen one cycle earlier is accepted. The bench drives directed frames whose mid-bit edges land two ticks before the limit and expects a clean decode. It also withholds edges entirely and expects a fault whose arrival time is judged against the tick rate. Random frames with random mid-bit timing then cover the space between those corners, with the expected fields worked out from the bit pattern in the bench.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ARM,
        S_ST_RISE,
        S_ST_FALL,
        S_SAMPLE,
        S_MID,
        S_DONE,
        S_FAULT
    } rx_state_e;
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
    parameter int DIV = 512
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          wrap;

    always_comb begin
        wrap  = (cnt_q == CW'(DIV - 1));
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign tick = wrap;
endmodule

// File: rtl/ir_line_sync.sv
module ir_line_sync (
    input  logic clk,
    input  logic rst,
    input  logic line_n,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q   <= line_n;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign lvl  = s2_q;
    assign rise = s2_q & ~prev_q;
    assign fall = ~s2_q & prev_q;
endmodule

// File: rtl/ir_biphase_rx.sv
module ir_biphase_rx
    import ir_rx_pkg::*;
#(
    parameter int TICK_DIV = 512,
    parameter int Q_TICKS  = 7,
    parameter int TQ_TICKS = 21,
    parameter int SYS_W    = 5,
    parameter int CMD_W    = 6,
    parameter int OUT_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ir_n,
    output logic [OUT_W-1:0] sys_addr,
    output logic [OUT_W-1:0] cmd,
    output logic             result_valid,
    output logic             result_err
);
    localparam int NBITS = 1 + SYS_W + CMD_W;
    localparam int TW    = $clog2(TQ_TICKS + 1);
    localparam int CW    = $clog2(NBITS + 1);

    typedef struct packed {
        rx_state_e        st;
        logic [TW-1:0]    tmr;
        logic [CW-1:0]    cnt;
        logic [NBITS-1:0] sh;
        logic             lvl;
        logic [OUT_W-1:0] sys;
        logic [OUT_W-1:0] cmd;
        logic             vld;
        logic             err;
    } regs_t;

    regs_t r_d, r_q;
    logic  tick_w, lvl_w, rise_w, fall_w, timeout;

    ir_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick_w)
    );

    ir_line_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .line_n(ir_n),
        .lvl   (lvl_w),
        .rise  (rise_w),
        .fall  (fall_w)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        timeout = (r_q.tmr >= TW'(TQ_TICKS));
        if (tick_w && !timeout) r_d.tmr = r_q.tmr + 1'b1;

        unique case (r_q.st)
            S_IDLE: begin
                r_d.tmr = '0;
                if (lvl_w) r_d.st = S_ARM;
            end
            S_ARM: begin
                r_d.tmr = '0;
                if (fall_w) r_d.st = S_ST_RISE;
            end
            S_ST_RISE: begin
                if (timeout) r_d.st = S_FAULT;
                else if (rise_w) begin
                    r_d.tmr = '0;
                    r_d.st  = S_ST_FALL;
                end
            end
            S_ST_FALL: begin
                if (timeout) r_d.st = S_FAULT;
                else if (fall_w) begin
                    r_d.tmr = '0;
                    r_d.cnt = '0;
                    r_d.st  = S_SAMPLE;
                end
            end
            S_SAMPLE: begin
                if (r_q.tmr >= TW'(Q_TICKS)) begin
                    r_d.sh  = {r_q.sh[NBITS-2:0], lvl_w};
                    r_d.lvl = lvl_w;
                    r_d.st  = S_MID;
                end
            end
            S_MID: begin
                if (timeout) r_d.st = S_FAULT;
                else if (r_q.lvl ? fall_w : rise_w) begin
                    r_d.tmr = '0;
                    r_d.cnt = r_q.cnt + 1'b1;
                    r_d.st  = (r_q.cnt == CW'(NBITS - 1)) ? S_DONE : S_SAMPLE;
                end
            end
            S_DONE: begin
                r_d.sys = OUT_W'(r_q.sh[CMD_W +: SYS_W]);
                r_d.cmd = OUT_W'({r_q.sh[NBITS-1], r_q.sh[CMD_W-1:0]});
                r_d.vld = 1'b1;
                r_d.err = 1'b0;
                r_d.st  = S_IDLE;
            end
            S_FAULT: begin
                r_d.sys = '1;
                r_d.cmd = '1;
                r_d.vld = 1'b1;
                r_d.err = 1'b1;
                r_d.st  = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st  <= S_IDLE;
            r_q.tmr <= '0;
            r_q.cnt <= '0;
            r_q.sh  <= '0;
            r_q.lvl <= 1'b0;
            r_q.sys <= '0;
            r_q.cmd <= '0;
            r_q.vld <= 1'b0;
            r_q.err <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sys_addr     = r_q.sys;
    assign cmd          = r_q.cmd;
    assign result_valid = r_q.vld;
    assign result_err   = r_q.err;

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R7
    fault_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (result_valid && result_err) |-> (sys_addr == '1 && cmd == '1));

    // R8
    good_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (result_valid && !result_err) |->
            (cmd[OUT_W-1] == 1'b0 && sys_addr[OUT_W-1:SYS_W] == '0));

    // R6
    mid_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == S_MID && r_q.tmr >= TW'(TQ_TICKS)) |=> (r_q.st == S_FAULT));

    // R10
    tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == S_MID && $past(r_q.st) == S_MID && !$past(tick_w))
            |-> (r_q.tmr == $past(r_q.tmr)));

    // R9
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        (!result_valid && $past(!rst)) |-> ($stable(sys_addr) && $stable(cmd)));
endmodule

// File: tb/tb_ir_biphase_rx.sv
module tb_ir_biphase_rx;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV = 4;
    localparam int QT   = 7;
    localparam int TQT  = 21;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ir_n = 1'b1;
    logic [7:0] sys_addr, cmd;
    logic       result_valid, result_err;

    int n_tests = 0, n_fail = 0;
    int nres = 0, dbl = 0, cyc = 0, last_cyc = 0;
    logic [7:0] last_sys, last_cmd;
    logic last_err, prev_v = 1'b0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_biphase_rx #(.TICK_DIV(TDIV), .Q_TICKS(QT), .TQ_TICKS(TQT)) dut (
        .clk(clk), .rst(rst), .ir_n(ir_n),
        .sys_addr(sys_addr), .cmd(cmd),
        .result_valid(result_valid), .result_err(result_err)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (result_valid) begin
                nres = nres + 1;
                last_sys = sys_addr;
                last_cmd = cmd;
                last_err = result_err;
                last_cyc = cyc;
                if (prev_v) dbl = dbl + 1;
            end
            prev_v = result_valid;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * TDIV) @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] exp_sys(input logic [11:0] b);
        return {3'b000, b[10:6]};
    endfunction

    function automatic logic [7:0] exp_cmd(input logic [11:0] b);
        return {1'b0, b[11], b[5:0]};
    endfunction

    task automatic send_frame(input logic [11:0] b, input int mid, input int bad);
        ir_n = 1'b1; wait_ticks(8);
        ir_n = 1'b0; wait_ticks(10);
        ir_n = 1'b1; wait_ticks(10);
        ir_n = 1'b0;
        for (int i = 11; i >= 0; i--) begin
            wait_ticks(2);
            ir_n = b[i];
            if (i == bad) begin
                wait_ticks(30);
                return;
            end
            wait_ticks(mid - 2);
            ir_n = ~b[i];
        end
        wait_ticks(2);
        ir_n = 1'b1;
        wait_ticks(3);
    endtask

    task automatic good_frame(input logic [11:0] b, input int mid);
        int base;
        base = nres;
        send_frame(b, mid, -1);
        check("R9 one result", nres, base + 1);
        check("R4 no error", last_err, 0);
        check("R8 sys", last_sys, exp_sys(b));
        check("R8 cmd", last_cmd, exp_cmd(b));
    endtask

    task automatic expect_fault(input string req, input int base);
        check({req, " one result"}, nres, base + 1);
        check({req, " R7 err"}, last_err, 1);
        check({req, " R7 sys"}, last_sys, 8'hFF);
        check({req, " R7 cmd"}, last_cmd, 8'hFF);
    endtask

    initial begin
        int base, c0;
        void'($urandom(32'd1234));
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 sys", sys_addr, 0);
        check("R1 cmd", cmd, 0);
        check("R1 valid", result_valid, 0);
        check("R1 err", result_err, 0);

        // R4 R8 directed patterns
        good_frame(12'hABC, 14);
        good_frame(12'h000, 14);
        good_frame(12'hFFF, 14);
        good_frame(12'h800, 14);
        good_frame(12'h7C0, 14);
        // R5 edge two ticks before the limit, and short bits
        good_frame(12'h5A5, TQT - 2);
        good_frame(12'h3C3, QT + 3);

        // R6 missing mid-bit edge, line left at 0
        base = nres;
        send_frame(12'h000, 14, 5);
        expect_fault("R6", base);

        // R2 line held low, then high: no result
        base = nres;
        wait_ticks(40);
        ir_n = 1'b1;
        wait_ticks(40);
        check("R2 no result", nres, base);

        // R3 rising edge of first start bit missing; R10 timing
        base = nres;
        ir_n = 1'b0;
        c0 = cyc;
        wait_ticks(30);
        expect_fault("R3 start1", base);
        check("R10 timeout early", (last_cyc - c0) >= (TQT - 1) * TDIV, 1);
        check("R10 timeout late", (last_cyc - c0) <= (TQT + 1) * TDIV + 8, 1);

        // R3 second start falling edge missing
        ir_n = 1'b1; wait_ticks(10);
        base = nres;
        ir_n = 1'b0; wait_ticks(10);
        ir_n = 1'b1; wait_ticks(30);
        expect_fault("R3 start2", base);

        // R5 random patterns with random mid-bit timing
        for (int k = 0; k < 10; k++) begin
            logic [11:0] b;
            b = 12'($urandom);
            good_frame(b, int'($urandom_range(QT + 2, TQT - 2)));
        end

        // R6 random fault position
        base = nres;
        send_frame(12'($urandom), 14, int'($urandom_range(0, 11)));
        expect_fault("R6 random", base);

        check("R9 single-cycle pulses", dbl, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * CLK_PERIOD);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule